// File: doc/BRIEF.md
# Store Posting Queue

This block sits between a write-through cache and a slow main memory. Every processor store goes into the cache and, in the same cycle, into this queue. The processor therefore does not wait for the memory to finish a write. A drain state machine then sends the queued writes to memory one at a time, oldest first. The memory port uses a valid/ready handshake and may take several cycles to accept each write.

The processor is held back only when every slot is occupied and no slot frees in that cycle. A load port compares its address with every pending entry. When an entry matches, the load gets that entry's data, because the memory does not hold it yet. An empty flag lets fence or flush logic wait until all posted writes have reached memory.

The drain controller has two states. In `DR_IDLE` the memory port is quiet. In `DR_ISSUE` the head entry is driven on the memory port. The transition *arm* goes from `DR_IDLE` to `DR_ISSUE` when a store is accepted, or when an entry is already waiting. The transition *retire_last* goes from `DR_ISSUE` to `DR_IDLE` when memory accepts the only remaining entry and no store arrives in that cycle. The transition *retire_next* stays in `DR_ISSUE` after any other accepted write. The transition *hold* stays in `DR_ISSUE` while memory is not ready.

Top module: `wpq_top`

## Requirements
- R1: After reset is released, `q_empty` is 1, `q_full` is 0 and `mem_valid` is 0.
- R2: A store is taken in every cycle where `st_valid` is 1 and `st_stall` is 0. `st_stall` is 1 only when the queue holds DEPTH entries and no memory handshake completes in that cycle.
- R3: Writes leave on the memory port in the order their stores were accepted, each with the address, data and byte enables of that store.
- R4: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr`, `mem_data` and `mem_be` hold their values into the next cycle.
- R5: An entry leaves the queue only in a cycle where `mem_valid` and `mem_ready` are both 1. Each such cycle removes exactly one entry.
- R6: `q_full` is 1 exactly when DEPTH entries are held (default DEPTH is 4). `q_empty` is 1 exactly when no entries are held.
- R7: When the queue is full and a handshake completes, a store in the same cycle is accepted without stall. The queue then remains full and loses no entry.
- R8: `ld_hit` is 1 when `ld_addr` equals the address of any held entry. `ld_data` and `ld_be` then come from the most recently accepted matching entry. `ld_hit` is 0 when nothing matches.
- R9: A store accepted into an empty queue raises `mem_valid` in the first cycle after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Processor store request |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_stall | output | 1 | Store not taken this cycle |
| ld_addr | input | AW | Load address to check against held entries |
| ld_hit | output | 1 | Load address matches a held entry |
| ld_data | output | DW | Data of the newest matching entry |
| ld_be | output | DW/8 | Byte enables of the newest matching entry |
| mem_valid | output | 1 | Write offered to memory |
| mem_addr | output | AW | Address of the offered write |
| mem_data | output | DW | Data of the offered write |
| mem_be | output | DW/8 | Byte enables of the offered write |
| mem_ready | input | 1 | Memory accepts the offered write |
| q_full | output | 1 | All slots occupied |
| q_empty | output | 1 | No slots occupied |

## Verification
A store and the retirement of the head entry can fall in the same cycle. This matters most when the queue is full, because the stall then depends on the memory handshake in that very cycle. The bench provokes this by issuing stores back to back against a memory that answers only after several cycles, so the queue saturates and handshakes land on cycles with pending stores. A behavioural queue model is compared with the design in every cycle: stall, flags, memory port and forwarded load data. The bench also counts the full-queue push-and-pop cycles, so it can confirm that the case was really reached.

// File: rtl/wpq_pkg.sv
package wpq_pkg;
    typedef enum logic [0:0] {
        DR_IDLE  = 1'b0,
        DR_ISSUE = 1'b1
    } drain_state_t;
endpackage

// File: rtl/wpq_store_ring.sv
module wpq_store_ring #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int BEW  = DW / 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [AW-1:0]  push_addr,
    input  logic [DW-1:0]  push_data,
    input  logic [BEW-1:0] push_be,
    input  logic           pop,
    output logic [AW-1:0]  head_addr,
    output logic [DW-1:0]  head_data,
    output logic [BEW-1:0] head_be,
    output logic [PW-1:0]  head_ptr,
    output logic [CW-1:0]  count,
    output logic [AW-1:0]  slot_addr [DEPTH],
    output logic [DW-1:0]  slot_data [DEPTH],
    output logic [BEW-1:0] slot_be   [DEPTH]
);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] occ;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= step_ptr(wr_ptr);
            if (pop)  rd_ptr <= step_ptr(rd_ptr);
            unique case ({push, pop})
                2'b10:   occ <= occ + CW'(1);
                2'b01:   occ <= occ - CW'(1);
                default: occ <= occ;
            endcase
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wr_ptr == PW'(g)) begin
                slot_addr[g] <= push_addr;
                slot_data[g] <= push_data;
                slot_be[g]   <= push_be;
            end
        end
    end

    assign head_addr = slot_addr[rd_ptr];
    assign head_data = slot_data[rd_ptr];
    assign head_be   = slot_be[rd_ptr];
    assign head_ptr  = rd_ptr;
    assign count     = occ;
endmodule

// File: rtl/wpq_hazard.sv
module wpq_hazard #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int BEW  = DW / 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [AW-1:0]  ld_addr,
    input  logic [PW-1:0]  head_ptr,
    input  logic [CW-1:0]  count,
    input  logic [AW-1:0]  slot_addr [DEPTH],
    input  logic [DW-1:0]  slot_data [DEPTH],
    input  logic [BEW-1:0] slot_be   [DEPTH],
    output logic           hit,
    output logic [DW-1:0]  hit_data,
    output logic [BEW-1:0] hit_be
);
    // Walk from oldest to newest; a later match overwrites an earlier one,
    // so the newest matching entry wins.
    always_comb begin
        int idx;
        hit      = 1'b0;
        hit_data = '0;
        hit_be   = '0;
        idx      = 0;
        for (int age = 0; age < DEPTH; age++) begin
            idx = (int'(head_ptr) + age) % DEPTH;
            if (age < int'(count) && slot_addr[idx] == ld_addr) begin
                hit      = 1'b1;
                hit_data = slot_data[idx];
                hit_be   = slot_be[idx];
            end
        end
    end
endmodule

// File: rtl/wpq_drain_fsm.sv
module wpq_drain_fsm
    import wpq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic holding,
    input  logic last_one,
    input  logic mem_ready,
    output logic mem_valid,
    output logic retire
);
    drain_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE: begin
                if (accept || holding) state_d = DR_ISSUE;          // arm
            end
            DR_ISSUE: begin
                if (mem_ready && last_one && !accept) state_d = DR_IDLE; // retire_last
                else                                  state_d = DR_ISSUE; // retire_next / hold
            end
            default: state_d = DR_IDLE;
        endcase
    end

    always_comb begin
        mem_valid = 1'b0;
        retire    = 1'b0;
        unique case (state_q)
            DR_IDLE:  ;
            DR_ISSUE: begin
                mem_valid = 1'b1;
                retire    = mem_ready;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/wpq_top.sv
module wpq_top #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int BEW  = DW / 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           st_valid,
    input  logic [AW-1:0]  st_addr,
    input  logic [DW-1:0]  st_data,
    input  logic [BEW-1:0] st_be,
    output logic           st_stall,
    input  logic [AW-1:0]  ld_addr,
    output logic           ld_hit,
    output logic [DW-1:0]  ld_data,
    output logic [BEW-1:0] ld_be,
    output logic           mem_valid,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_data,
    output logic [BEW-1:0] mem_be,
    input  logic           mem_ready,
    output logic           q_full,
    output logic           q_empty
);
    logic           accept, retire;
    logic [CW-1:0]  count;
    logic [PW-1:0]  head_ptr;
    logic [AW-1:0]  slot_addr [DEPTH];
    logic [DW-1:0]  slot_data [DEPTH];
    logic [BEW-1:0] slot_be   [DEPTH];

    assign q_full   = (count == CW'(DEPTH));
    assign q_empty  = (count == '0);
    assign st_stall = q_full && !retire;
    assign accept   = st_valid && !st_stall;

    wpq_store_ring #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) ring_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_addr (st_addr),
        .push_data (st_data),
        .push_be   (st_be),
        .pop       (retire),
        .head_addr (mem_addr),
        .head_data (mem_data),
        .head_be   (mem_be),
        .head_ptr  (head_ptr),
        .count     (count),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .slot_be   (slot_be)
    );

    wpq_hazard #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) hazard_i (
        .ld_addr   (ld_addr),
        .head_ptr  (head_ptr),
        .count     (count),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .slot_be   (slot_be),
        .hit       (ld_hit),
        .hit_data  (ld_data),
        .hit_be    (ld_be)
    );

    wpq_drain_fsm drain_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .holding   (!q_empty),
        .last_one  (count == CW'(1)),
        .mem_ready (mem_ready),
        .mem_valid (mem_valid),
        .retire    (retire)
    );
endmodule

// File: rtl/wpq_chk.sv
module wpq_chk #(
    parameter int AW  = 16,
    parameter int DW  = 32,
    localparam int BEW = DW / 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           st_valid,
    input logic           st_stall,
    input logic           ld_hit,
    input logic           mem_valid,
    input logic [AW-1:0]  mem_addr,
    input logic [DW-1:0]  mem_data,
    input logic [BEW-1:0] mem_be,
    input logic           mem_ready,
    input logic           q_full,
    input logic           q_empty
);
    assert_stall_only_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> q_full);

    assert_port_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_data) && $stable(mem_be)));

    assert_retire_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !(st_valid && !st_stall)) |=> !q_full);

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_full && q_empty));

    assert_full_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && mem_valid && mem_ready && st_valid) |-> !st_stall ##1 q_full);

    assert_hit_needs_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit |-> !q_empty);

    assert_issue_after_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty && st_valid) |=> mem_valid);
endmodule

bind wpq_top wpq_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .st_stall  (st_stall),
    .ld_hit    (ld_hit),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .mem_be    (mem_be),
    .mem_ready (mem_ready),
    .q_full    (q_full),
    .q_empty   (q_empty)
);

// File: tb/wpq_tb.sv
module wpq_top_tb_top;
    localparam int DEPTH = 4;
    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int BEW   = DW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 1'b0;
    logic [AW-1:0]  st_addr = '0;
    logic [DW-1:0]  st_data = '0;
    logic [BEW-1:0] st_be = '0;
    logic [AW-1:0]  ld_addr = '0;
    logic mem_ready = 1'b0;
    logic st_stall, ld_hit, mem_valid, q_full, q_empty;
    logic [DW-1:0]  ld_data, mem_data;
    logic [BEW-1:0] ld_be, mem_be;
    logic [AW-1:0]  mem_addr;

    always #5 clk = ~clk;

    wpq_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (.*);

    typedef struct {
        logic [AW-1:0]  a;
        logic [DW-1:0]  d;
        logic [BEW-1:0] b;
    } ent_t;

    ent_t model[$];
    int checks = 0;
    int errors = 0;
    int wait_cnt = 0;
    int lat = 3;
    int swap_events = 0;
    int dup_hits = 0;
    logic [31:0] lfsr = 32'hACE1_1234;
    logic [DW-1:0] serial = 32'h1000_0000;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    // One clock: drive at the falling edge, compare, then advance the model.
    task automatic step(input logic sv, input logic [AW-1:0] a, input logic [AW-1:0] la);
        logic e_full, e_empty, pop, stall, push, e_hit;
        logic [DW-1:0] e_ld;
        logic [BEW-1:0] e_ldbe;
        int nmatch;
        @(negedge clk);
        st_valid  = sv;
        st_addr   = a;
        st_data   = serial;
        st_be     = serial[3:0] | 4'b0001;
        ld_addr   = la;
        mem_ready = (model.size() != 0) && (wait_cnt >= lat);
        #1;
        e_full  = (model.size() == DEPTH);
        e_empty = (model.size() == 0);
        chk("R6 full", 64'(q_full), 64'(e_full));
        chk("R6 empty", 64'(q_empty), 64'(e_empty));
        chk("R9 mem_valid", 64'(mem_valid), 64'(!e_empty));
        if (!e_empty) begin
            chk("R3 mem_addr", 64'(mem_addr), 64'(model[0].a));
            chk("R3/R4 mem_data", 64'(mem_data), 64'(model[0].d));
            chk("R3/R4 mem_be", 64'(mem_be), 64'(model[0].b));
        end
        pop   = !e_empty && mem_ready;
        stall = e_full && !pop;
        chk("R2 st_stall", 64'(st_stall), 64'(stall));
        e_hit = 1'b0; e_ld = '0; e_ldbe = '0; nmatch = 0;
        foreach (model[i]) begin
            if (model[i].a == la) begin
                e_hit = 1'b1; e_ld = model[i].d; e_ldbe = model[i].b; nmatch++;
            end
        end
        if (nmatch > 1) dup_hits++;
        chk("R8 ld_hit", 64'(ld_hit), 64'(e_hit));
        if (e_hit) begin
            chk("R8 ld_data", 64'(ld_data), 64'(e_ld));
            chk("R8 ld_be", 64'(ld_be), 64'(e_ldbe));
        end
        push = sv && !stall;
        if (e_full && pop && push) swap_events++;
        if (pop) begin
            void'(model.pop_front());
            wait_cnt = 0;
        end else if (!e_empty) begin
            wait_cnt++;
        end
        if (push) begin
            model.push_back('{a: a, d: serial, b: serial[3:0] | 4'b0001});
            serial = serial + 1;
        end
    endtask

    function automatic logic [AW-1:0] pick_addr();
        logic [31:0] r;
        r = rnd();
        return AW'({r[2:0], 2'b00}) + AW'(16'h0100);
    endfunction

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle outputs right after reset.
        @(negedge clk); #1;
        chk("R1 empty", 64'(q_empty), 64'd1);
        chk("R1 full", 64'(q_full), 64'd0);
        chk("R1 mem_valid", 64'(mem_valid), 64'd0);

        // Slow memory, dense stores: saturates, stalls, full push+pop (R2 R5 R7).
        lat = 4;
        for (int n = 0; n < 300; n++) begin
            a = pick_addr();
            step(rnd() % 8 != 0, a, pick_addr());
        end
        // Fast memory, sparse stores (R3 R9).
        lat = 0;
        for (int n = 0; n < 300; n++) begin
            a = pick_addr();
            step(rnd() % 4 == 0, a, pick_addr());
        end
        // Medium memory, loads aimed at recent stores (R8 newest wins).
        lat = 2;
        for (int n = 0; n < 400; n++) begin
            a = pick_addr();
            step(rnd() % 2 == 0, a, a);
        end
        // Memory stalls long, then drains fully (R4 R6).
        lat = 12;
        for (int n = 0; n < 200; n++) step(1'b0, '0, 16'h0100);
        chk("R6 drained empty", 64'(q_empty), 64'd1);
        chk("R7 full push+pop seen", 64'(swap_events > 0), 64'd1);
        chk("R8 duplicate match seen", 64'(dup_hits > 0), 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule